// File: doc/BRIEF.md
# Page-Boundary Program Splitter

This block accepts one byte-write request at a time, made of a start byte address and a byte count, and breaks it into program commands for a downstream flash sequencer. A flash program command may not run past the end of a 256-byte page. The splitter therefore trims the first command so that it stops at the next page edge. Whole-page commands follow, and any short remainder is issued last.

Each command is offered on a valid/ready port. It carries the flash byte address, a length from 1 to 256, and the offset of its first byte within the caller's source buffer. The sequencer uses that offset to fetch the data bytes, so the splitter itself never touches data. Once the sequencer accepts the final command, a one-cycle done pulse follows. A request of zero bytes produces the pulse and no commands.

Top module: `page_split_top`

## Requirements
- R1: When start/256 equals (start+length)/256, computed without wrap, the request is issued as exactly one chunk carrying the full length, at the start address, with buffer offset 0.
- R2: Otherwise, the first chunk has length 256 minus (start address mod 256).
- R3: After the first chunk, every chunk issued while at least 256 bytes remain has length 256.
- R4: A remainder of 1 to 255 bytes is issued as the final chunk. A request whose remainder reaches exactly 0 issues no further chunk.
- R5: Each chunk's address and buffer offset equal the previous chunk's address and offset plus the previous chunk's length. The first chunk's offset is 0.
- R6: A zero-length request is accepted, raises done in the following cycle, and issues no chunk.
- R7: done is high for exactly one cycle, in the cycle after the last chunk handshake. While done is high, chunk_valid is low.
- R8: While chunk_valid is high and chunk_ready is low, chunk_valid, chunk_addr, chunk_len and chunk_offset hold their values.
- R9: req_ready is high only when no request is in progress. req_valid, req_addr and req_len have no effect while a request is in progress.
- R10: During and right after reset, req_ready=1, chunk_valid=0 and done=0.
- R11: Every chunk has a length of 1 to 256, and (address mod 256) + length is at most 256.
- R12: Chunk addresses wrap modulo 2^24 past 0xFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Splitter idle, request accepted on this cycle |
| req_addr | input | 24 | Start byte address |
| req_len | input | 16 | Byte count (0 allowed) |
| chunk_valid | output | 1 | Program chunk offered |
| chunk_ready | input | 1 | Sequencer takes the chunk |
| chunk_addr | output | 24 | Chunk start byte address |
| chunk_len | output | 9 | Chunk byte count, 1 to 256 |
| chunk_offset | output | 16 | Offset of the chunk's first byte in the source buffer |
| done | output | 1 | One-cycle pulse after the final chunk is accepted |

## Verification
The bench uses the default parameters: 24-bit addresses, 16-bit lengths and a 256-byte page. With these values, every page-edge case is reachable with short requests. Those cases are a request inside one page, a request ending exactly on an edge, a single byte at offset 255, several whole pages, and a request that wraps past the top of the address space. A stall pattern on chunk_ready exercises the hold behaviour. Stray request traffic while busy shows that the splitter ignores it.

// File: rtl/psplit_pkg.sv
package psplit_pkg;
    typedef enum logic {
        PS_IDLE  = 1'b0,
        PS_ISSUE = 1'b1
    } ps_mode_e;
endpackage

// File: rtl/psplit_chunk_calc.sv
// Picks the size of the next chunk: the room left in the current page,
// or the remaining count if that is smaller.
module psplit_chunk_calc #(
    parameter int PAGE_SHIFT = 8,
    parameter int LEN_W      = 16
) (
    input  logic [PAGE_SHIFT-1:0] page_off,
    input  logic [LEN_W-1:0]      remain,
    output logic [PAGE_SHIFT:0]   clen,
    output logic                  is_last
);
    localparam int CW = PAGE_SHIFT + 1;
    localparam logic [CW-1:0] PAGE_BYTES = {1'b1, {PAGE_SHIFT{1'b0}}};

    logic [CW-1:0]    room;
    logic [LEN_W-1:0] room_w;

    always_comb begin
        room    = PAGE_BYTES - {1'b0, page_off};
        room_w  = LEN_W'(room);
        is_last = (remain <= room_w);
        clen    = is_last ? remain[CW-1:0] : room;
    end
endmodule

// File: rtl/psplit_advance.sv
// Steps the address, buffer offset and remaining count by one chunk.
module psplit_advance #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int PAGE_SHIFT = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LEN_W-1:0]    off,
    input  logic [LEN_W-1:0]    rem,
    input  logic [PAGE_SHIFT:0] clen,
    output logic [ADDR_W-1:0]   addr_nx,
    output logic [LEN_W-1:0]    off_nx,
    output logic [LEN_W-1:0]    rem_nx
);
    always_comb begin
        addr_nx = addr + ADDR_W'(clen);
        off_nx  = off + LEN_W'(clen);
        rem_nx  = rem - LEN_W'(clen);
    end
endmodule

// File: rtl/page_split_top.sv
module page_split_top
    import psplit_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int PAGE_SHIFT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    output logic                  chunk_valid,
    input  logic                  chunk_ready,
    output logic [ADDR_W-1:0]     chunk_addr,
    output logic [PAGE_SHIFT:0]   chunk_len,
    output logic [LEN_W-1:0]      chunk_offset,
    output logic                  done
);
    typedef struct packed {
        ps_mode_e          mode;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  off;
        logic [LEN_W-1:0]  rem;
    } split_state_t;

    split_state_t s_d, s_q;

    logic [PAGE_SHIFT:0] clen;
    logic                is_last;
    logic [ADDR_W-1:0]   addr_nx;
    logic [LEN_W-1:0]    off_nx;
    logic [LEN_W-1:0]    rem_nx;

    psplit_chunk_calc #(
        .PAGE_SHIFT (PAGE_SHIFT),
        .LEN_W      (LEN_W)
    ) calc_i (
        .page_off (s_q.addr[PAGE_SHIFT-1:0]),
        .remain   (s_q.rem),
        .clen     (clen),
        .is_last  (is_last)
    );

    psplit_advance #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) adv_i (
        .addr    (s_q.addr),
        .off     (s_q.off),
        .rem     (s_q.rem),
        .clen    (clen),
        .addr_nx (addr_nx),
        .off_nx  (off_nx),
        .rem_nx  (rem_nx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.mode)
            PS_IDLE: begin
                if (req_valid) begin
                    if (req_len == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.mode = PS_ISSUE;
                        s_d.addr = req_addr;
                        s_d.off  = '0;
                        s_d.rem  = req_len;
                    end
                end
            end
            PS_ISSUE: begin
                if (chunk_ready) begin
                    s_d.addr = addr_nx;
                    s_d.off  = off_nx;
                    s_d.rem  = rem_nx;
                    if (is_last) begin
                        s_d.mode = PS_IDLE;
                        s_d.done = 1'b1;
                    end
                end
            end
            default: s_d.mode = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready    = (s_q.mode == PS_IDLE);
    assign chunk_valid  = (s_q.mode == PS_ISSUE);
    assign chunk_addr   = s_q.addr;
    assign chunk_len    = clen;
    assign chunk_offset = s_q.off;
    assign done         = s_q.done;
endmodule

// File: rtl/psplit_checker.sv
module psplit_checker #(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 16,
    parameter int PAGE_SHIFT = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                chunk_valid,
    input logic                chunk_ready,
    input logic [ADDR_W-1:0]   chunk_addr,
    input logic [PAGE_SHIFT:0] chunk_len,
    input logic [LEN_W-1:0]    chunk_offset,
    input logic                done
);
    localparam logic [PAGE_SHIFT+1:0] PAGE_W = {2'b01, {PAGE_SHIFT{1'b0}}};

    logic [PAGE_SHIFT+1:0] end_pos;
    logic [PAGE_SHIFT+1:0] len_w;

    always_comb begin
        len_w   = {1'b0, chunk_len};
        end_pos = {2'b00, chunk_addr[PAGE_SHIFT-1:0]} + len_w;
    end

    a_r11_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> (chunk_len != '0) && (len_w <= PAGE_W));

    a_r11_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> end_pos <= PAGE_W);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid && !chunk_ready |=> chunk_valid && $stable(chunk_addr)
            && $stable(chunk_len) && $stable(chunk_offset));

    a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid && chunk_ready |=> !chunk_valid ||
            ((chunk_addr == $past(chunk_addr) + ADDR_W'($past(chunk_len))) &&
             (chunk_offset == $past(chunk_offset) + LEN_W'($past(chunk_len)))));

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !chunk_valid && req_ready);

    a_r9_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && chunk_valid));
endmodule

bind page_split_top psplit_checker #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .chunk_valid  (chunk_valid),
    .chunk_ready  (chunk_ready),
    .chunk_addr   (chunk_addr),
    .chunk_len    (chunk_len),
    .chunk_offset (chunk_offset),
    .done         (done)
);

// File: tb/page_split_top_tb_top.sv
`timescale 1ns/1ps
module page_split_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        chunk_valid;
    logic        chunk_ready = 1'b0;
    logic [23:0] chunk_addr;
    logic [8:0]  chunk_len;
    logic [15:0] chunk_offset;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    page_split_top dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_len (req_len),
        .chunk_valid (chunk_valid), .chunk_ready (chunk_ready),
        .chunk_addr (chunk_addr), .chunk_len (chunk_len),
        .chunk_offset (chunk_offset), .done (done)
    );

    // {addr, len, stall}
    localparam int NV = 8;
    localparam logic [40:0] VEC [NV] = '{
        {24'h000010, 16'h0020, 1'b0},
        {24'h0000F0, 16'h0030, 1'b1},
        {24'h000100, 16'h0100, 1'b0},
        {24'h0012C0, 16'h0250, 1'b1},
        {24'h0000FF, 16'h0001, 1'b0},
        {24'h000000, 16'h0300, 1'b1},
        {24'hFFFF80, 16'h0180, 1'b0},
        {24'h000005, 16'h01FB, 1'b1}
    };

    logic [48:0] exp_c [64];
    int          exp_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected chunks from the page rule: same page -> one chunk, else
    // trimmed head, whole pages, short tail.
    task automatic build_exp(input logic [23:0] a, input int unsigned n);
        int unsigned sp, ep, cur, cnt, off, first;
        exp_n = 0;
        sp = a >> 8;
        ep = (a + n) >> 8;
        if (n == 0) return;
        if (sp == ep) begin
            exp_c[exp_n++] = {a, 9'(n), 16'd0};
            return;
        end
        first = 256 - (a % 256);
        exp_c[exp_n++] = {a, 9'(first), 16'd0};
        cur = a + first; cnt = n - first; off = first;
        while (cnt >= 256) begin
            exp_c[exp_n++] = {24'(cur), 9'd256, 16'(off)};
            cur += 256; cnt -= 256; off += 256;
        end
        if (cnt > 0) exp_c[exp_n++] = {24'(cur), 9'(cnt), 16'(off)};
    endtask

    task automatic run_req(input logic [23:0] a, input int unsigned n,
                           input bit stall, input bit noise);
        int idx = 0;
        int k = 0;
        bit prev_stall = 0;
        logic [48:0] prev = '0;
        logic [48:0] now;
        build_exp(a, n);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "idle req_ready", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_len = 16'(n);
        @(negedge clk);
        req_valid = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1 && chunk_valid == 1'b0, "R6", "zero-length done",
                {done, chunk_valid}, 2'b10);
        end else begin
            while (!done && k < 4000) begin
                now = {chunk_addr, chunk_len, chunk_offset};
                if (noise) begin
                    req_valid = 1'b1; req_addr = 24'hABCDEF; req_len = 16'd5;
                    chk(req_ready == 1'b0, "R9", "busy req_ready", req_ready, 0);
                end
                if (prev_stall)
                    chk(chunk_valid && now == prev, "R8", "held chunk", now, prev);
                if (chunk_valid) begin
                    chunk_ready = !(stall && (k % 3 == 0));
                    prev_stall = !chunk_ready;
                    prev = now;
                    if (chunk_ready) begin
                        if (idx < exp_n)
                            chk(now == exp_c[idx], "R1 R2 R3 R4 R5 R11 R12",
                                "chunk", now, exp_c[idx]);
                        else
                            chk(1'b0, "R4", "extra chunk", now, 0);
                        idx++;
                    end
                end else begin
                    chunk_ready = 1'b0;
                    prev_stall = 0;
                end
                @(negedge clk);
                k++;
            end
            req_valid = 1'b0;
            chunk_ready = 1'b0;
            chk(done == 1'b1 && chunk_valid == 1'b0, "R7", "done after last",
                {done, chunk_valid}, 2'b10);
            chk(idx == exp_n, "R4", "chunk count", idx, exp_n);
        end
        @(negedge clk);
        chk(done == 1'b0 && chunk_valid == 1'b0 && req_ready == 1'b1, "R7",
            "done single pulse", {done, chunk_valid, req_ready}, 3'b001);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && chunk_valid == 1'b0 && done == 1'b0, "R10",
            "in reset", {req_ready, chunk_valid, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && chunk_valid == 1'b0 && done == 1'b0, "R10",
            "after reset", {req_ready, chunk_valid, done}, 3'b100);

        for (int i = 0; i < NV; i++)
            run_req(VEC[i][40:17], VEC[i][16:1], VEC[i][0], 1'b0);

        // R6: zero-length request
        run_req(24'h000123, 0, 1'b0, 1'b0);
        // R9: stray requests while busy change nothing
        run_req(24'h0003F0, 16'h0220, 1'b1, 1'b1);
        @(negedge clk);
        chk(chunk_valid == 1'b0, "R9", "stray request not taken", chunk_valid, 0);
        // R3 R4: remainder lands exactly on a page edge, no tail chunk
        run_req(24'h000080, 16'h0180, 1'b0, 1'b0);
        // R12: wrap with a tail past the top of the address space
        run_req(24'hFFFFFE, 16'h0105, 1'b1, 1'b0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule